// File: doc/BRIEF.md
# Wrapping Video Fetch Address Generator

This block produces the stream of burst addresses that a display refresh engine reads from a frame buffer. The buffer is a circular region in memory bounded by a start address and a last-burst address. Each frame begins at a programmable initial address, so software can scroll the picture by changing only that one value. The initial address is the buffer start plus the vertical offset times the line length, where the line length in bytes is the horizontal resolution times the bits per pixel divided by eight.

Once a frame has started, the generator offers one burst address at a time on a valid/ready handshake. A downstream FIFO accepts an address when it has room. After each accepted burst the address moves forward by one burst size. After the burst at the last-burst address has been accepted, the next address is the buffer start. Software sets the last-burst register to the screen end minus one burst. The burst is a fixed 16 bytes in the plain-DRAM mode. In the dual-port-VRAM mode it is the programmed half shift-register size. The initial address is sampled only on the frame-start pulse, so a pan request takes effect on the following frame.

Top module: `vidScanAddrGen`

## Requirements
- R1: After reset, reqValid is 0 and stays 0 until a frameStart pulse is seen while cfgEnable is 1.
- R2: On a clock edge where frameStart and cfgEnable are both 1, in the next cycle reqValid is 1 and reqAddr equals the value cfgInit had at that edge.
- R3: A change of cfgInit between frame starts has no effect on the addresses issued; the new value is used at the next frameStart.
- R4: When a burst is accepted (reqValid and reqReady both 1, no frameStart) and reqAddr is below cfgEnd, the next reqAddr is reqAddr plus the burst size.
- R5: When a burst is accepted (no frameStart) and reqAddr is greater than or equal to cfgEnd, the next reqAddr is cfgStart.
- R6: The burst size in bytes is 16 when cfgVramMode is 0 and cfgHalfSam when cfgVramMode is 1.
- R7: While reqValid is 1 and reqReady is 0, reqAddr and reqValid hold their values.
- R8: When cfgEnable is 0, reqValid is 0 in the same cycle, and a frameStart is ignored. After cfgEnable returns to 1, no address is issued until the next frameStart.
- R9: A frameStart during an active frame reloads cfgInit. This also holds on a cycle where a burst is accepted: the reload takes priority over the advance and the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgEnable | input | 1 | Fetch enable |
| cfgVramMode | input | 1 | 0: 16-byte bursts, 1: bursts of cfgHalfSam bytes |
| cfgHalfSam | input | 8 | Burst size in bytes for VRAM mode |
| cfgStart | input | 16 | Buffer start byte address (wrap target) |
| cfgEnd | input | 16 | Last-burst byte address (screen end minus one burst) |
| cfgInit | input | 16 | Frame initial byte address (pan position) |
| frameStart | input | 1 | One-cycle pulse at vertical sync |
| reqAddr | output | 16 | Burst byte address offered to memory |
| reqValid | output | 1 | reqAddr is valid |
| reqReady | input | 1 | Downstream FIFO has room for a burst |

## Verification
The hardest case to reach is a frame-start pulse that lands on the same cycle as an accepted burst at the last-burst address. On that edge the reload, the wrap and the advance all compete. The bench sweeps the initial address across and beyond the last-burst address in both burst modes, with a ready pattern that stalls every third cycle. This brings the address onto the wrap point under both stalled and flowing conditions. It then pulses frameStart with ready held high to force the collision. A bench-side address model checks every cycle against the required reload, advance and wrap behaviour.

// File: rtl/vidScanPkg.sv
package vidScanPkg;
  typedef struct packed {
    logic load;     // take the frame initial address
    logic advance;  // step by one burst
    logic wrap;     // return to buffer start
  } scanStrobes_t;
endpackage

// File: rtl/vidScanDatapath.sv
module vidScanDatapath #(
  parameter int ADDR_W     = 16,
  parameter int BURST_W    = 8,
  parameter int DRAM_BURST = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  vidScanPkg::scanStrobes_t   strobes,
  input  logic                       cfgVramMode,
  input  logic [BURST_W-1:0]         cfgHalfSam,
  input  logic [ADDR_W-1:0]          cfgStart,
  input  logic [ADDR_W-1:0]          cfgEnd,
  input  logic [ADDR_W-1:0]          cfgInit,
  output logic [ADDR_W-1:0]          curAddr,
  output logic                       atEnd
);
  localparam logic [ADDR_W-1:0] DRAM_STEP = ADDR_W'(DRAM_BURST);

  logic [ADDR_W-1:0] burstBytes;

  always_comb begin
    burstBytes = cfgVramMode ? ADDR_W'(cfgHalfSam) : DRAM_STEP;
    atEnd      = (curAddr >= cfgEnd);
  end

  always_ff @(posedge clk) begin
    if (!rstN)               curAddr <= '0;
    else if (strobes.load)   curAddr <= cfgInit;
    else if (strobes.wrap)   curAddr <= cfgStart;
    else if (strobes.advance) curAddr <= curAddr + burstBytes;
  end

  AST_LOAD_NEXT: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |=> curAddr == $past(cfgInit)); // R2
endmodule

// File: rtl/vidScanControl.sv
module vidScanControl (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     cfgEnable,
  input  logic                     frameStart,
  input  logic                     reqReady,
  input  logic                     atEnd,
  output vidScanPkg::scanStrobes_t strobes,
  output logic                     reqValid
);
  logic running;
  logic fire;

  always_ff @(posedge clk) begin
    if (!rstN)           running <= 1'b0;
    else if (!cfgEnable) running <= 1'b0;
    else if (frameStart) running <= 1'b1;
  end

  always_comb begin
    reqValid        = running && cfgEnable;
    fire            = reqValid && reqReady;
    strobes.load    = frameStart && cfgEnable;
    strobes.wrap    = fire && !strobes.load && atEnd;
    strobes.advance = fire && !strobes.load && !atEnd;
  end

  AST_START_ONLY_ON_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    $rose(reqValid) |-> $past(frameStart)); // R1
  AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgEnable && !running) |=> !running); // R8
endmodule

// File: rtl/vidScanAddrGen.sv
module vidScanAddrGen #(
  parameter int ADDR_W     = 16,
  parameter int BURST_W    = 8,
  parameter int DRAM_BURST = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgEnable,
  input  logic               cfgVramMode,
  input  logic [BURST_W-1:0] cfgHalfSam,
  input  logic [ADDR_W-1:0]  cfgStart,
  input  logic [ADDR_W-1:0]  cfgEnd,
  input  logic [ADDR_W-1:0]  cfgInit,
  input  logic               frameStart,
  output logic [ADDR_W-1:0]  reqAddr,
  output logic               reqValid,
  input  logic               reqReady
);
  vidScanPkg::scanStrobes_t strobes;
  logic atEnd;

  vidScanControl ctrl_i (
    .clk(clk), .rstN(rstN), .cfgEnable(cfgEnable), .frameStart(frameStart),
    .reqReady(reqReady), .atEnd(atEnd), .strobes(strobes), .reqValid(reqValid)
  );

  vidScanDatapath #(.ADDR_W(ADDR_W), .BURST_W(BURST_W), .DRAM_BURST(DRAM_BURST)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .cfgVramMode(cfgVramMode),
    .cfgHalfSam(cfgHalfSam), .cfgStart(cfgStart), .cfgEnd(cfgEnd),
    .cfgInit(cfgInit), .curAddr(reqAddr), .atEnd(atEnd)
  );

  AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqReady && !frameStart && cfgEnable) |=> ($stable(reqAddr) && reqValid)); // R7
  AST_STEP_BURST: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && !frameStart && reqAddr < cfgEnd) |=>
      reqAddr == $past(reqAddr) + ($past(cfgVramMode) ? ADDR_W'($past(cfgHalfSam)) : ADDR_W'(DRAM_BURST))); // R4 R6
  AST_WRAP_TO_START: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && !frameStart && reqAddr >= cfgEnd) |=> reqAddr == $past(cfgStart)); // R5
  AST_RELOAD_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (frameStart && cfgEnable && reqValid && reqReady) |=> reqAddr == $past(cfgInit)); // R9
endmodule

// File: tb/vidScanAddrGen_tb_top.sv
module vidScanAddrGen_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rstN, cfgEnable, cfgVramMode, frameStart, reqReady, reqValid;
  logic [7:0]  cfgHalfSam;
  logic [15:0] cfgStart, cfgEnd, cfgInit, reqAddr;

  vidScanAddrGen dut_i (
    .clk(clk), .rstN(rstN), .cfgEnable(cfgEnable), .cfgVramMode(cfgVramMode),
    .cfgHalfSam(cfgHalfSam), .cfgStart(cfgStart), .cfgEnd(cfgEnd), .cfgInit(cfgInit),
    .frameStart(frameStart), .reqAddr(reqAddr), .reqValid(reqValid), .reqReady(reqReady)
  );

  int errs = 0, checks = 0;
  bit expRun = 0, finished = 0;
  logic [15:0] expA = '0;

  function automatic logic [15:0] burstOf();
    return cfgVramMode ? 16'(cfgHalfSam) : 16'd16; // R6
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick(bit rdy, bit fs, string req);
    string tag;
    reqReady = rdy; frameStart = fs; #1;
    tag = req;
    if (!cfgEnable) expRun = 0;
    else if (fs) begin expRun = 1; expA = cfgInit; end
    else if (expRun && rdy) begin
      if (expA >= cfgEnd) begin expA = cfgStart; tag = "R5"; end
      else expA = expA + burstOf();
    end
    @(negedge clk);
    chk(reqValid == (expRun && cfgEnable), tag, "valid", reqValid, expRun && cfgEnable);
    if (expRun && cfgEnable) chk(reqAddr == expA, tag, "addr", reqAddr, expA);
  endtask

  initial begin
    rstN = 0; cfgEnable = 1; cfgVramMode = 0; cfgHalfSam = 8'd32;
    cfgStart = 16'h0200; cfgEnd = 16'h0250; cfgInit = 16'h0220;
    frameStart = 0; reqReady = 1;
    repeat (3) @(negedge clk);
    chk(reqValid == 0, "R1", "valid in reset", reqValid, 0);
    rstN = 1;
    for (int i = 0; i < 4; i++) tick(1, 0, "R1");

    tick(1, 1, "R2");
    for (int i = 0; i < 10; i++) tick(1, 0, "R4");

    // stall: address and valid held
    for (int i = 0; i < 4; i++) tick(0, 0, "R7");
    tick(1, 0, "R7");

    // pan written mid-frame, used only at next frame start
    cfgInit = 16'h0240;
    for (int i = 0; i < 6; i++) tick(i % 2, 0, "R3");
    tick(1, 1, "R3");
    for (int i = 0; i < 3; i++) tick(1, 0, "R3");

    // sweep both burst modes and initial offsets across the wrap point
    for (int m = 0; m < 3; m++) begin
      cfgVramMode = (m != 0);
      cfgHalfSam  = (m == 2) ? 8'd48 : 8'd32;
      cfgEnd = cfgStart + 16'd5 * burstOf();
      for (int k = 0; k < 8; k++) begin
        cfgInit = cfgStart + 16'(k) * burstOf();
        tick(1, 1, "R2");
        for (int i = 0; i < 20; i++) tick((i % 3) != 0, 0, (m != 0) ? "R6" : "R4");
      end
    end

    // frame start colliding with an accepted burst, including at the wrap point
    cfgVramMode = 0; cfgEnd = 16'h0250; cfgInit = 16'h0210;
    tick(1, 1, "R9");
    for (int i = 0; i < 4; i++) tick(1, 0, "R9");
    chk(reqAddr == 16'h0250, "R9", "at last burst", reqAddr, 16'h0250);
    cfgInit = 16'h0230;
    tick(1, 1, "R9");
    chk(reqAddr == 16'h0230, "R9", "reload beats wrap", reqAddr, 16'h0230);

    // enable off: valid drops at once, frame start ignored, restart needs new frame start
    cfgEnable = 0; #1;
    chk(reqValid == 0, "R8", "valid when disabled", reqValid, 0);
    tick(1, 1, "R8");
    tick(1, 0, "R8");
    cfgEnable = 1;
    for (int i = 0; i < 3; i++) tick(1, 0, "R8");
    tick(1, 1, "R8");
    tick(1, 0, "R8");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule